// File: doc/BRIEF.md
# Three-Plane Glyph RAM Write Port

This block holds a user-definable character set as three separate bit planes. Each plane stores 256 glyphs of 8×8 pixels, with 8 bytes per glyph. The CPU fills the planes through a 2 KiB write-only memory window. One CPU write can reach any subset of the planes at the same offset, so a single store paints a glyph row in any of the eight colours. A mode register opens and closes the window, and a mask register selects which planes a write reaches. While the window is closed, writes in its range are handed on to the memory underneath.

A video-side read port takes a glyph code and a row number and returns one byte per plane one cycle later. Taken together, the three bytes give a 3-bit colour for each of the eight pixels, with bit 7 as the leftmost pixel. After reset a hardware sweep zeroes every plane. The window stays closed and the video port returns zero until the sweep has finished.

Top module: `glyph_ram_top`

## Requirements
- R1: After reset the window is closed, the plane mask is 0, and once the clear sweep is over every glyph row of every plane reads back as 0x00.
- R2: An I/O write at offset 0xEA loads the plane mask from data bits [2:0] and drops bits [7:3]. Mask bit i (i = 0..2) enables plane i. I/O writes at any offset other than 0xE9 and 0xEA change no state.
- R3: An I/O write at offset 0xE9 opens the window when data bit 0 is 1 and closes it when bit 0 is 0, starting with the next cycle.
- R4: With the window open, a CPU write at address 0xA000+n (n < 0x800) stores the data byte at offset n of every plane whose mask bit is set, at that clock edge. Planes whose mask bit is clear keep their contents.
- R5: With the window closed, a CPU write in 0xA000–0xA7FF raises `fallWr` in the same cycle and leaves all planes unchanged.
- R6: A CPU read in 0xA000–0xA7FF raises `fallRd` whether the window is open or closed, so glyph data is never returned to the CPU.
- R7: A CPU write outside 0xA000–0xA7FF changes no plane and leaves `fallWr` low.
- R8: The video port reads offset {vidCode, vidRow}. One clock later, `vidRowBits[8p+7:8p]` holds that offset of plane p.
- R9: If a video read and a CPU write hit the same offset in the same cycle, the video port returns the contents from before the write.
- R10: The clear sweep runs for 2048 cycles after reset is released. During the sweep the video port returns 0, the window behaves as closed even if the mode bit is set, and mode and mask writes are still taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWr | input | 1 | I/O register write strobe |
| ioAddr | input | 8 | I/O register offset |
| ioData | input | 8 | I/O write data |
| memWr | input | 1 | CPU memory write strobe |
| memRd | input | 1 | CPU memory read strobe |
| memAddr | input | 16 | CPU memory address |
| memData | input | 8 | CPU memory write data |
| fallWr | output | 1 | Window-range write handed to the underlying memory |
| fallRd | output | 1 | Window-range read handed to the underlying memory |
| vidCode | input | 8 | Glyph code for the video read |
| vidRow | input | 3 | Row within the glyph for the video read |
| vidRowBits | output | 24 | Plane bytes, plane p at bits [8p+7:8p] |

## Verification
The bench builds the block with its default parameters: 8 glyph-code bits and 3 row bits, giving the full 2048-byte plane depth, the window at 0xA000 and the registers at 0xE9 and 0xEA. At this depth the bench can watch the whole 2048-cycle clear sweep and check that mode and mask writes made during the sweep still take effect afterwards. It also reaches both edges of the window (0x9FFF and 0xA800) and all eight plane-mask patterns. Video reads are steered onto recently written offsets, so the same-cycle read-while-write ordering is exercised both in directed steps and in random ones.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  localparam int PLANE_COUNT = 3;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic [PLANE_COUNT-1:0] planeWe;
    logic                   blank;
  } ctlStrobe_t;
endpackage

// File: rtl/glyph_ctrl.sv
module glyph_ctrl
  import glyph_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int CPU_AW = 16,
  parameter logic [CPU_AW-1:0] WIN_BASE = 16'hA000,
  parameter logic [7:0] MODE_PORT = 8'hE9,
  parameter logic [7:0] MASK_PORT = 8'hEA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWr,
  input  logic [7:0]        ioAddr,
  input  logic [DATA_W-1:0] ioData,
  input  logic              memWr,
  input  logic              memRd,
  input  logic [CPU_AW-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output ctlStrobe_t        strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              fallWr,
  output logic              fallRd
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);

  logic                   modeBit;
  logic [PLANE_COUNT-1:0] maskReg;
  logic                   clearing;
  logic [ADDR_W-1:0]      sweepIdx;
  logic                   inWin;
  logic                   mapped;
  logic                   winWr;

  // registers and clear sweep
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeBit  <= 1'b0;
      maskReg  <= '0;
      clearing <= 1'b1;
      sweepIdx <= '0;
    end else begin
      if (ioWr && ioAddr == MODE_PORT) modeBit <= ioData[0];
      if (ioWr && ioAddr == MASK_PORT) maskReg <= ioData[PLANE_COUNT-1:0];
      if (clearing) begin
        sweepIdx <= sweepIdx + 1'b1;
        if (sweepIdx == LAST_IDX) clearing <= 1'b0;
      end
    end
  end

  always_comb begin
    inWin  = memAddr[CPU_AW-1:ADDR_W] == WIN_BASE[CPU_AW-1:ADDR_W];
    mapped = modeBit && !clearing;
    winWr  = memWr && inWin && mapped;
    fallWr = memWr && inWin && !mapped;
    fallRd = memRd && inWin;

    strobe.blank = clearing;
    if (clearing) begin
      strobe.planeWe = '1;
      wrAddr         = sweepIdx;
      wrData         = '0;
    end else begin
      strobe.planeWe = winWr ? maskReg : '0;
      wrAddr         = memAddr[ADDR_W-1:0];
      wrData         = memData;
    end
  end
endmodule

// File: rtl/glyph_planes.sv
module glyph_planes
  import glyph_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobe_t                    strobe,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [ADDR_W-1:0]             rdAddr,
  output logic [PLANE_COUNT*DATA_W-1:0] rowBits
);
  localparam int DEPTH = 1 << ADDR_W;

  logic                          blankQ;
  logic [PLANE_COUNT*DATA_W-1:0] rdQ;

  always_ff @(posedge clk) begin
    if (!rstN) blankQ <= 1'b1;
    else       blankQ <= strobe.blank;
  end

  for (genvar p = 0; p < PLANE_COUNT; p++) begin : gPlane
    logic [DATA_W-1:0] store [DEPTH];

    // read-first port: the read sees contents from before a same-edge write
    always_ff @(posedge clk) begin
      if (strobe.planeWe[p]) store[wrAddr] <= wrData;
      rdQ[p*DATA_W +: DATA_W] <= store[rdAddr];
    end
  end

  assign rowBits = blankQ ? '0 : rdQ;
endmodule

// File: rtl/glyph_ram_top.sv
module glyph_ram_top
  import glyph_pkg::*;
#(
  parameter int GLYPH_BITS = 8,
  parameter int ROW_BITS = 3,
  parameter logic [15:0] WIN_BASE = 16'hA000,
  parameter logic [7:0] MODE_PORT = 8'hE9,
  parameter logic [7:0] MASK_PORT = 8'hEA
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          ioWr,
  input  logic [7:0]                    ioAddr,
  input  logic [7:0]                    ioData,
  input  logic                          memWr,
  input  logic                          memRd,
  input  logic [15:0]                   memAddr,
  input  logic [7:0]                    memData,
  output logic                          fallWr,
  output logic                          fallRd,
  input  logic [GLYPH_BITS-1:0]         vidCode,
  input  logic [ROW_BITS-1:0]           vidRow,
  output logic [PLANE_COUNT*DATA_W-1:0] vidRowBits
);
  localparam int ADDR_W = GLYPH_BITS + ROW_BITS;

  ctlStrobe_t        ctlStrobe;
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;

  glyph_ctrl #(
    .ADDR_W(ADDR_W), .CPU_AW(16), .WIN_BASE(WIN_BASE),
    .MODE_PORT(MODE_PORT), .MASK_PORT(MASK_PORT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioAddr(ioAddr), .ioData(ioData),
    .memWr(memWr), .memRd(memRd), .memAddr(memAddr), .memData(memData),
    .strobe(ctlStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .fallWr(fallWr), .fallRd(fallRd)
  );

  glyph_planes #(.ADDR_W(ADDR_W)) uPlanes (
    .clk(clk), .rstN(rstN), .strobe(ctlStrobe), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr({vidCode, vidRow}), .rowBits(vidRowBits)
  );
endmodule

// File: rtl/glyph_ram_chk.sv
module glyph_ram_chk #(
  parameter int ADDR_W = 11,
  parameter logic [15:0] WIN_BASE = 16'hA000
) (
  input logic        clk,
  input logic        rstN,
  input logic        memWr,
  input logic        memRd,
  input logic [15:0] memAddr,
  input logic        fallWr,
  input logic        fallRd,
  input logic [2:0]  planeWe,
  input logic        blank,
  input logic [2:0]  maskReg,
  input logic [23:0] vidRowBits
);
  logic inWin;
  assign inWin = memAddr[15:ADDR_W] == WIN_BASE[15:ADDR_W];

  // R5
  fall_no_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fallWr && !blank) |-> planeWe == 3'b000);

  // R4
  mask_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !blank |-> (planeWe & ~maskReg) == 3'b000);

  // R7
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !inWin && !blank) |-> (!fallWr && planeWe == 3'b000));

  // R6
  read_passes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && inWin) |-> fallRd);

  // R10
  sweep_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    !blank |=> !blank);

  // R10
  blank_video_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(blank) |-> vidRowBits == 24'h0);
endmodule

bind glyph_ram_top glyph_ram_chk #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) uChk (
  .clk(clk), .rstN(rstN), .memWr(memWr), .memRd(memRd), .memAddr(memAddr),
  .fallWr(fallWr), .fallRd(fallRd), .planeWe(ctlStrobe.planeWe),
  .blank(ctlStrobe.blank), .maskReg(uCtrl.maskReg), .vidRowBits(vidRowBits)
);

// File: tb/glyph_ram_top_test.sv
`timescale 1ns/1ps
module glyph_ram_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioWr = 1'b0;
  logic [7:0]  ioAddr = 8'h00;
  logic [7:0]  ioData = 8'h00;
  logic        memWr = 1'b0;
  logic        memRd = 1'b0;
  logic [15:0] memAddr = 16'h0000;
  logic [7:0]  memData = 8'h00;
  logic        fallWr;
  logic        fallRd;
  logic [7:0]  vidCode = 8'h00;
  logic [2:0]  vidRow = 3'h0;
  logic [23:0] vidRowBits;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  // bench model
  bit         swept = 1'b0;
  bit         modeM = 1'b0;
  logic [2:0] maskM = 3'b000;
  logic [7:0] shadow [3][2048];

  glyph_ram_top uut (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioAddr(ioAddr), .ioData(ioData),
    .memWr(memWr), .memRd(memRd), .memAddr(memAddr), .memData(memData),
    .fallWr(fallWr), .fallRd(fallRd), .vidCode(vidCode), .vidRow(vidRow),
    .vidRowBits(vidRowBits)
  );

  always #4 clk = ~clk;

  function automatic bit inWindow(input logic [15:0] a);
    return a[15:11] == 5'b10100;
  endfunction

  function automatic logic [23:0] expRow(input logic [10:0] off);
    if (!swept) return 24'h0;
    return {shadow[2][off], shadow[1][off], shadow[0][off]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [23:0] act,
                       input logic [23:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit doIo, input logic [7:0] ia, input logic [7:0] id,
                      input bit doWr, input bit doRd, input logic [15:0] ma,
                      input logic [7:0] md, input logic [10:0] va, input string tag);
    logic [23:0] ev;
    bit mappedM;
    @(negedge clk);
    ioWr = doIo; ioAddr = ia; ioData = id;
    memWr = doWr; memRd = doRd; memAddr = ma; memData = md;
    vidCode = va[10:3]; vidRow = va[2:0];
    #1;
    mappedM = modeM && swept;
    check(fallWr == (doWr && inWindow(ma) && !mappedM),
          doWr && !inWindow(ma) ? {tag, " R7 fallWr"} : {tag, " R5 fallWr"},
          24'(fallWr), 24'(doWr && inWindow(ma) && !mappedM));
    check(fallRd == (doRd && inWindow(ma)), {tag, " R6 fallRd"},
          24'(fallRd), 24'(doRd && inWindow(ma)));
    ev = expRow(va);
    @(posedge clk);
    #1;
    check(vidRowBits == ev, {tag, " R4/R8/R9 video"}, vidRowBits, ev);
    if (doIo && ia == 8'hE9) modeM = id[0];
    if (doIo && ia == 8'hEA) maskM = id[2:0];
    if (doWr && inWindow(ma) && mappedM)
      for (int p = 0; p < 3; p++) if (maskM[p]) shadow[p][ma[10:0]] = md;
    ioWr = 1'b0; memWr = 1'b0; memRd = 1'b0;
  endtask

  task automatic idle(input logic [10:0] va, input string tag);
    step(0, 8'h00, 8'h00, 0, 0, 16'h0000, 8'h00, va, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [10:0] lastOff = 11'h005;
    for (int p = 0; p < 3; p++) for (int i = 0; i < 2048; i++) shadow[p][i] = 8'h00;
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    #1;
    check(vidRowBits == 24'h0, "R1 reset video", vidRowBits, 24'h0);
    check(fallWr == 1'b0 && fallRd == 1'b0, "R1 reset fall", {fallWr, fallRd}, 24'h0);
    @(negedge clk); rstN = 1'b1;

    // R10: registers accepted during sweep, window still closed, video blank
    step(1, 8'hE9, 8'h01, 0, 0, 16'h0, 8'h0, 11'h005, "R10 mode in sweep");
    step(1, 8'hEA, 8'h07, 0, 0, 16'h0, 8'h0, 11'h005, "R10 mask in sweep");
    step(0, 8'h0, 8'h0, 1, 0, 16'hA005, 8'hEE, 11'h005, "R10 write in sweep");
    repeat (2100) @(posedge clk);
    swept = 1'b1;

    // R1: contents zero after sweep
    for (int i = 0; i < 4; i++) idle(11'($urandom_range(0, 2047)), "R1 cleared");
    idle(11'h005, "R1 R10 sweep-time write dropped");

    // R3 R4: mode and mask from the sweep still apply: all planes
    step(0, 8'h0, 8'h0, 1, 0, 16'hA005, 8'h3C, 11'h005, "R4 all planes");
    idle(11'h005, "R4 all planes read");
    // R2: upper bits dropped, only plane 1
    step(1, 8'hEA, 8'hFA, 0, 0, 16'h0, 8'h0, 11'h005, "R2 mask write");
    step(0, 8'h0, 8'h0, 1, 0, 16'hA005, 8'h81, 11'h005, "R2 R4 single plane");
    idle(11'h005, "R2 R4 single plane read");
    // R2: other offset ignored
    step(1, 8'hEB, 8'h00, 0, 0, 16'h0, 8'h0, 11'h005, "R2 other offset");
    step(1, 8'hE8, 8'h00, 0, 0, 16'h0, 8'h0, 11'h005, "R2 other offset");
    step(0, 8'h0, 8'h0, 1, 0, 16'hA005, 8'h55, 11'h005, "R9 collide");
    idle(11'h005, "R9 after collide");
    // window edges
    step(1, 8'hEA, 8'h07, 0, 0, 16'h0, 8'h0, 11'h7FF, "R2 mask all");
    step(0, 8'h0, 8'h0, 1, 0, 16'hA7FF, 8'hA5, 11'h7FF, "R4 top edge");
    step(0, 8'h0, 8'h0, 1, 0, 16'hA800, 8'h11, 11'h000, "R7 above window");
    step(0, 8'h0, 8'h0, 1, 0, 16'h9FFF, 8'h22, 11'h7FF, "R7 below window");
    idle(11'h000, "R7 offset 0 untouched");
    step(0, 8'h0, 8'h0, 0, 1, 16'hA005, 8'h0, 11'h005, "R6 read open");
    // R3 R5: close window
    step(1, 8'hE9, 8'hFE, 0, 0, 16'h0, 8'h0, 11'h005, "R3 close");
    step(0, 8'h0, 8'h0, 1, 0, 16'hA005, 8'h99, 11'h005, "R5 closed write");
    step(0, 8'h0, 8'h0, 0, 1, 16'hA123, 8'h0, 11'h005, "R6 read closed");
    idle(11'h005, "R5 unchanged");
    step(1, 8'hE9, 8'h01, 0, 0, 16'h0, 8'h0, 11'h005, "R3 reopen");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 9);
      logic [10:0] va = ($urandom_range(0, 1) == 1) ? lastOff : 11'($urandom_range(0, 2047));
      logic [7:0] d = 8'($urandom);
      logic [15:0] a;
      case (r)
        0: step(1, 8'hE9, d, 0, 0, 16'h0, 8'h0, va, "R3 rnd mode");
        1: step(1, 8'hEA, d, 0, 0, 16'h0, 8'h0, va, "R2 rnd mask");
        2: step(1, 8'hE0, d, 0, 0, 16'h0, 8'h0, va, "R2 rnd other io");
        3, 4, 5, 6, 7: begin
          if ($urandom_range(0, 4) != 0) a = 16'hA000 | 16'($urandom_range(0, 2047));
          else a = 16'($urandom);
          if (inWindow(a)) lastOff = a[10:0];
          step(0, 8'h0, 8'h0, 1, 0, a, d, va, "R4 rnd write");
        end
        8: step(0, 8'h0, 8'h0, 0, 1, 16'($urandom), 8'h0, va, "R6 rnd read");
        default: idle(va, "R8 rnd idle");
      endcase
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule